// File: doc/BRIEF.md
# Machine Status Register with Restricted Alias Views

This block keeps the machine-level status word of a hart in one 64-bit register and answers three views of it: a machine view that sees nearly all of it, and a supervisor view and a user view that see and modify only a subset. Each access picks a view, an operation (overwrite, set bits or clear bits) and an access width. The 32-bit width relocates the two top storage bits to the top of the narrow word. It hides the middle of the register, including the two XLEN code fields, which a narrow access can therefore never disturb.

The storage always uses the 64-bit arrangement, whatever width the hart runs at. Reset loads the XLEN code of the hart into the user and supervisor XLEN fields. Static capability inputs state whether user and supervisor modes exist. An absent mode forces its XLEN field to zero and forbids that mode's code in the previous-privilege field. Whenever an accepted access leaves any of the four interrupt-enable bits set, the block pulses a request for the interrupt logic to re-evaluate pending interrupts.

Top module: `status_csr`

## Requirements
- R1: Synchronous active-high reset loads bits 12:11 (previous privilege) with 2'b11, the user XLEN field at bits 33:32 and the supervisor XLEN field at bits 35:34 with 2'b10 when `xlen64` is 1 or 2'b01 when it is 0 (a field whose mode is absent loads 2'b00), and every other bit with 0.
- R2: With `rd_wide`=0 the read returns, in bits 31:30, storage bits 63:62 and, in bits 29:0, storage bits 29:0, both after the view's read mask; bits 63:32 of `rd_data` are zero.
- R3: An access with `acc_wide`=0 takes `acc_wdata[31:30]` as the operand for storage bits 63:62 and `acc_wdata[29:0]` for bits 29:0; storage bits 61:30, including both XLEN fields, keep their value.
- R4: `acc_op` 2'b00 replaces the bits selected by the effective write mask with the operand; 2'b01 ORs the masked operand in; 2'b10 and 2'b11 clear the bits set in the masked operand. The effective mask is the view's write mask ANDed with the width's reach.
- R5: `acc_view` 2'b00 is machine (write mask 64'hC000_000F_3FFF_FFFF), 2'b01 is supervisor (write mask 64'h8000_0000_0000_0133), 2'b10 and 2'b11 are user (write mask 64'h0000_0000_0000_0011); bits outside the selected write mask are never changed.
- R6: A read returns the storage ANDed with the read mask of `rd_view`: machine 64'hC000_000F_3FFF_FFFF, supervisor 64'h8000_0003_0000_0133, user 64'h8000_0003_0000_0011.
- R7: An access whose result would leave 2'b00 in bits 12:11 while `cap_user`=0, or 2'b01 while `cap_super`=0, keeps the previous value of bits 12:11; the rest of the access still takes effect.
- R8: When `cap_user`=0 bits 33:32 hold and read zero, and when `cap_super`=0 bits 35:34 hold and read zero; otherwise a 64-bit machine write may set them.
- R9: `irq_recheck` is high for the one cycle after an edge that accepted an access whose new value has any of bits 3:0 set, and low otherwise.
- R10: Reads are combinational from storage; an access takes effect at the next clock edge, so a read in the same cycle still returns the value before the access.
- R11: In a cycle with `acc_valid`=0 the storage is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_user | input | 1 | User mode exists (static) |
| cap_super | input | 1 | Supervisor mode exists (static) |
| xlen64 | input | 1 | Hart runs 64-bit (1) or 32-bit (0); used at reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_view | input | 2 | View of the access: 00 machine, 01 supervisor, 1x user |
| acc_op | input | 2 | 00 overwrite, 01 set bits, 1x clear bits |
| acc_wide | input | 1 | 1: 64-bit access, 0: 32-bit access |
| acc_wdata | input | 64 | Operand of the access |
| rd_view | input | 2 | View of the read port, same coding as `acc_view` |
| rd_wide | input | 1 | 1: 64-bit read, 0: 32-bit read |
| rd_data | output | 64 | Combinational read result |
| irq_recheck | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
A modifying access and a read of the same register fall in the same cycle, and the read must see the old contents. Every access in the bench is issued with the read port aimed at some view. The read is judged 1 ns after the access is driven, against the reference model's state before the update, and judged again after the edge against the updated state. The capability-driven legalization and the XLEN code fields can also meet in one update: a 64-bit machine write of all ones under each capability mix must leave absent fields at zero while the rest of the word changes.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef enum logic [1:0] {VW_MACH, VW_SUP, VW_USR} view_e;
  typedef enum logic [1:0] {OP_WR, OP_SET, OP_CLR} op_e;

  localparam int IE_W   = 4;   // interrupt-enable bits at the bottom of the word
  localparam int MPP_LO = 11;  // previous-privilege field, 2 bits
  localparam int UXL_LO = 32;  // user XLEN code, 2 bits
  localparam int SXL_LO = 34;  // supervisor XLEN code, 2 bits
  localparam int XL_W   = 2;

  function automatic view_e decode_view(input logic [1:0] code);
    case (code)
      2'b00:   return VW_MACH;
      2'b01:   return VW_SUP;
      default: return VW_USR;
    endcase
  endfunction

  function automatic op_e decode_op(input logic [1:0] code);
    case (code)
      2'b00:   return OP_WR;
      2'b01:   return OP_SET;
      default: return OP_CLR;
    endcase
  endfunction

  function automatic logic [1:0] xl_code(input logic is64);
    return is64 ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/status_path_xlat.sv
// Maps an access operand onto the 64-bit storage layout and reports
// which storage bits the chosen access width can reach.
module status_path_xlat #(
  parameter int DW = 64,
  parameter int NW = 32
) (
  input  logic          wide,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] op_val,
  output logic [DW-1:0] reach
);
  localparam int LOW_W = NW - 2;
  localparam int GAP_W = DW - NW;
  localparam logic [DW-1:0] NARROW_REACH = {2'b11, {GAP_W{1'b0}}, {LOW_W{1'b1}}};

  always_comb begin
    if (wide) begin
      op_val = wdata;
      reach  = '1;
    end else begin
      op_val = {wdata[NW-1 -: 2], {GAP_W{1'b0}}, wdata[LOW_W-1:0]};
      reach  = NARROW_REACH;
    end
  end
endmodule

// File: rtl/status_update.sv
// Next-state computation: masked overwrite / set / clear, then
// legalization of the previous-privilege and XLEN fields.
module status_update import status_pkg::*; #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] op_val,
  input  logic [DW-1:0] eff_mask,
  input  op_e           op,
  input  logic          cap_user,
  input  logic          cap_super,
  output logic [DW-1:0] nxt
);
  logic [DW-1:0] raw;
  logic [1:0]    cap_vec;
  logic [1:0]    mpp_new;
  logic          mpp_bad;

  assign cap_vec = {cap_super, cap_user};

  always_comb begin
    case (op)
      OP_WR:   raw = (cur & ~eff_mask) | (op_val & eff_mask);
      OP_SET:  raw = cur | (op_val & eff_mask);
      default: raw = cur & ~(op_val & eff_mask);
    endcase
  end

  assign mpp_new = raw[MPP_LO +: 2];
  assign mpp_bad = ((mpp_new == 2'b00) && !cap_user) ||
                   ((mpp_new == 2'b01) && !cap_super);

  always_comb begin
    nxt = raw;
    if (mpp_bad) nxt[MPP_LO +: 2] = cur[MPP_LO +: 2];
    for (int i = 0; i < 2; i++) begin
      if (!cap_vec[i]) nxt[UXL_LO + i*XL_W +: XL_W] = '0;
    end
  end
endmodule

// File: rtl/status_read_view.sv
// Combinational read port: view mask, then optional 32-bit compression.
module status_read_view import status_pkg::*; #(
  parameter int            DW      = 64,
  parameter int            NW      = 32,
  parameter logic [DW-1:0] M_RMASK = '1,
  parameter logic [DW-1:0] S_RMASK = '1,
  parameter logic [DW-1:0] U_RMASK = '1
) (
  input  logic [DW-1:0] st,
  input  logic [1:0]    view,
  input  logic          wide,
  output logic [DW-1:0] data
);
  localparam int LOW_W = NW - 2;
  logic [DW-1:0] filt;
  logic [DW-1:0] rmask;

  always_comb begin
    case (decode_view(view))
      VW_MACH: rmask = M_RMASK;
      VW_SUP:  rmask = S_RMASK;
      default: rmask = U_RMASK;
    endcase
  end

  assign filt = st & rmask;

  always_comb begin
    if (wide) data = filt;
    else      data = {{(DW-NW){1'b0}}, filt[DW-1 -: 2], filt[LOW_W-1:0]};
  end
endmodule

// File: rtl/status_csr.sv
module status_csr import status_pkg::*; #(
  parameter int            DW      = 64,
  parameter int            NW      = 32,
  parameter logic [DW-1:0] M_RMASK = 64'hC000_000F_3FFF_FFFF,
  parameter logic [DW-1:0] M_WMASK = 64'hC000_000F_3FFF_FFFF,
  parameter logic [DW-1:0] S_RMASK = 64'h8000_0003_0000_0133,
  parameter logic [DW-1:0] S_WMASK = 64'h8000_0000_0000_0133,
  parameter logic [DW-1:0] U_RMASK = 64'h8000_0003_0000_0011,
  parameter logic [DW-1:0] U_WMASK = 64'h0000_0000_0000_0011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_user,
  input  logic          cap_super,
  input  logic          xlen64,
  input  logic          acc_valid,
  input  logic [1:0]    acc_view,
  input  logic [1:0]    acc_op,
  input  logic          acc_wide,
  input  logic [DW-1:0] acc_wdata,
  input  logic [1:0]    rd_view,
  input  logic          rd_wide,
  output logic [DW-1:0] rd_data,
  output logic          irq_recheck
);
  logic [DW-1:0] st_q;
  logic [DW-1:0] op_val, reach, wmask, nxt, rst_val;
  logic          irq_q;

  status_path_xlat #(.DW(DW), .NW(NW)) xlat_i (
    .wide   (acc_wide),
    .wdata  (acc_wdata),
    .op_val (op_val),
    .reach  (reach)
  );

  always_comb begin
    case (decode_view(acc_view))
      VW_MACH: wmask = M_WMASK;
      VW_SUP:  wmask = S_WMASK;
      default: wmask = U_WMASK;
    endcase
  end

  status_update #(.DW(DW)) upd_i (
    .cur       (st_q),
    .op_val    (op_val),
    .eff_mask  (wmask & reach),
    .op        (decode_op(acc_op)),
    .cap_user  (cap_user),
    .cap_super (cap_super),
    .nxt       (nxt)
  );

  status_read_view #(
    .DW(DW), .NW(NW),
    .M_RMASK(M_RMASK), .S_RMASK(S_RMASK), .U_RMASK(U_RMASK)
  ) rd_i (
    .st   (st_q),
    .view (rd_view),
    .wide (rd_wide),
    .data (rd_data)
  );

  always_comb begin
    rst_val = '0;
    rst_val[MPP_LO +: 2] = 2'b11;
    if (cap_user)  rst_val[UXL_LO +: XL_W] = xl_code(xlen64);
    if (cap_super) rst_val[SXL_LO +: XL_W] = xl_code(xlen64);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= rst_val;
      irq_q <= 1'b0;
    end else begin
      irq_q <= acc_valid && (|nxt[IE_W-1:0]);
      if (acc_valid) st_q <= nxt;
    end
  end

  assign irq_recheck = irq_q;
endmodule

// File: rtl/status_csr_chk.sv
module status_csr_chk #(
  parameter int            DW      = 64,
  parameter logic [DW-1:0] U_WMASK = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          cap_user,
  input logic          cap_super,
  input logic          acc_valid,
  input logic [1:0]    acc_view,
  input logic          acc_wide,
  input logic          irq_recheck,
  input logic [DW-1:0] st_q
);
  assert_narrow_keeps_xl_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wide) |=> (st_q[35:32] == $past(st_q[35:32])));

  assert_user_view_scope_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_view[1]) |=> (((st_q ^ $past(st_q)) & ~U_WMASK) == '0));

  assert_mpp_no_user_R7: assert property (@(posedge clk) disable iff (rst)
    !cap_user |-> (st_q[12:11] != 2'b00));

  assert_mpp_no_super_R7: assert property (@(posedge clk) disable iff (rst)
    !cap_super |-> (st_q[12:11] != 2'b01));

  assert_uxl_absent_R8: assert property (@(posedge clk) disable iff (rst)
    !cap_user |-> (st_q[33:32] == 2'b00));

  assert_sxl_absent_R8: assert property (@(posedge clk) disable iff (rst)
    !cap_super |-> (st_q[35:34] == 2'b00));

  assert_recheck_cause_R9: assert property (@(posedge clk) disable iff (rst)
    irq_recheck |-> ($past(acc_valid) && (st_q[3:0] != 4'h0)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(st_q));
endmodule

bind status_csr status_csr_chk #(.DW(DW), .U_WMASK(U_WMASK)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cap_user    (cap_user),
  .cap_super   (cap_super),
  .acc_valid   (acc_valid),
  .acc_view    (acc_view),
  .acc_wide    (acc_wide),
  .irq_recheck (irq_recheck),
  .st_q        (st_q)
);

// File: tb/status_csr_tb_top.sv
`timescale 1ns/1ps
module status_csr_tb_top;
  localparam logic [63:0] MR = 64'hC000_000F_3FFF_FFFF, MW = 64'hC000_000F_3FFF_FFFF;
  localparam logic [63:0] SR = 64'h8000_0003_0000_0133, SW = 64'h8000_0000_0000_0133;
  localparam logic [63:0] UR = 64'h8000_0003_0000_0011, UW = 64'h0000_0000_0000_0011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_user = 1'b1, cap_super = 1'b1, xlen64 = 1'b1;
  logic acc_valid = 1'b0, acc_wide = 1'b1, rd_wide = 1'b1;
  logic [1:0] acc_view = 2'b00, acc_op = 2'b00, rd_view = 2'b00;
  logic [63:0] acc_wdata = '0;
  logic [63:0] rd_data;
  logic irq_recheck;

  logic [63:0] m_st;
  logic m_irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  status_csr dut_i (
    .clk(clk), .rst(rst), .cap_user(cap_user), .cap_super(cap_super), .xlen64(xlen64),
    .acc_valid(acc_valid), .acc_view(acc_view), .acc_op(acc_op), .acc_wide(acc_wide),
    .acc_wdata(acc_wdata), .rd_view(rd_view), .rd_wide(rd_wide),
    .rd_data(rd_data), .irq_recheck(irq_recheck)
  );

  function automatic logic [63:0] wmask_of(input logic [1:0] v);
    if (v == 2'b00) return MW;
    if (v == 2'b01) return SW;
    return UW;
  endfunction

  function automatic logic [63:0] rmask_of(input logic [1:0] v);
    if (v == 2'b00) return MR;
    if (v == 2'b01) return SR;
    return UR;
  endfunction

  function automatic logic [63:0] model_next(input logic [63:0] cur, input logic [1:0] v,
      input logic [1:0] op, input logic w, input logic [63:0] d);
    logic [63:0] opd, em, n;
    opd = w ? d : {d[31:30], 32'h0, d[29:0]};
    em  = wmask_of(v) & (w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hC000_0000_3FFF_FFFF);
    if (op == 2'b00)      n = (cur & ~em) | (opd & em);
    else if (op == 2'b01) n = cur | (opd & em);
    else                  n = cur & ~(opd & em);
    if ((n[12:11] == 2'b00 && !cap_user) || (n[12:11] == 2'b01 && !cap_super))
      n[12:11] = cur[12:11];
    if (!cap_user)  n[33:32] = 2'b00;
    if (!cap_super) n[35:34] = 2'b00;
    return n;
  endfunction

  function automatic logic [63:0] exp_read(input logic [1:0] v, input logic w);
    logic [63:0] f;
    f = m_st & rmask_of(v);
    return w ? f : {32'h0, f[63:62], f[29:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic x64, input logic cu, input logic cs);
    acc_valid = 1'b0; rst = 1'b1;
    xlen64 = x64; cap_user = cu; cap_super = cs;
    repeat (2) @(posedge clk);
    m_st = '0;
    m_st[12:11] = 2'b11;
    if (cu) m_st[33:32] = x64 ? 2'b10 : 2'b01;
    if (cs) m_st[35:34] = x64 ? 2'b10 : 2'b01;
    m_irq = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int v = 0; v < 3; v++) begin
      for (int w = 0; w < 2; w++) begin
        rd_view = 2'(v); rd_wide = w[0];
        #1 check("R1 reset read", rd_data, exp_read(2'(v), w[0]));
      end
    end
    check("R1 reset recheck", {63'h0, irq_recheck}, 64'h0);
  endtask

  task automatic access(input string tag, input logic [1:0] v, input logic [1:0] op,
      input logic w, input logic [63:0] d, input logic [1:0] rv, input logic rw);
    acc_valid = 1'b1; acc_view = v; acc_op = op; acc_wide = w; acc_wdata = d;
    rd_view = rv; rd_wide = rw;
    #1 check("R10 old value in access cycle", rd_data, exp_read(rv, rw));
    @(posedge clk);
    m_st  = model_next(m_st, v, op, w, d);
    m_irq = |m_st[3:0];
    @(negedge clk);
    acc_valid = 1'b0;
    #1 check(tag, rd_data, exp_read(rv, rw));
    check("R9 recheck after access", {63'h0, irq_recheck}, {63'h0, m_irq});
  endtask

  task automatic idle(input string tag, input logic [1:0] rv, input logic rw);
    acc_valid = 1'b0; rd_view = rv; rd_wide = rw;
    @(posedge clk);
    m_irq = 1'b0;
    @(negedge clk);
    #1 check(tag, rd_data, exp_read(rv, rw));
    check("R9 recheck idle", {63'h0, irq_recheck}, 64'h0);
  endtask

  task automatic run_config(input logic x64, input logic cu, input logic cs);
    do_reset(x64, cu, cs);
    access("R2 narrow machine write", 2'b00, 2'b00, 1'b0, 64'h0000_0000_FFFF_FFFF, 2'b00, 1'b0);
    idle("R3 XLEN fields kept by narrow write", 2'b00, 1'b1);
    access("R3 narrow write high bits", 2'b00, 2'b00, 1'b0, 64'hFFFF_FFFF_0000_0000, 2'b00, 1'b1);
    access("R8 wide machine write ones", 2'b00, 2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b1);
    access("R5 supervisor write zeros", 2'b01, 2'b00, 1'b1, 64'h0, 2'b00, 1'b1);
    access("R4 user set bits", 2'b10, 2'b01, 1'b0, 64'hFFFF_FFFF, 2'b00, 1'b1);
    access("R4 supervisor clear bits", 2'b01, 2'b10, 1'b1, 64'h0000_0000_0000_0003, 2'b00, 1'b1);
    idle("R6 supervisor read", 2'b01, 1'b1);
    idle("R6 user read", 2'b11, 1'b1);
    idle("R11 idle keeps storage", 2'b00, 1'b1);
    access("R7 previous privilege 00", 2'b00, 2'b00, 1'b1, 64'h0, 2'b00, 1'b1);
    access("R7 previous privilege 01", 2'b00, 2'b01, 1'b1, 64'h0000_0000_0000_0800, 2'b00, 1'b1);
    access("R7 previous privilege 10", 2'b00, 2'b00, 1'b0, 64'h0000_0000_0000_1000, 2'b00, 1'b1);
    access("R7 clear to 00", 2'b00, 2'b11, 1'b1, 64'h0000_0000_0000_1800, 2'b00, 1'b1);
    access("R9 enable bit on", 2'b10, 2'b01, 1'b1, 64'h1, 2'b00, 1'b0);
    access("R9 enable bits off", 2'b00, 2'b10, 1'b1, 64'hF, 2'b00, 1'b0);
    for (int k = 0; k < 250; k++) begin
      logic [1:0] v, op, rv;
      logic w, rw;
      logic [63:0] d;
      string tg;
      v = 2'($urandom_range(0, 3)); op = 2'($urandom_range(0, 3));
      w = 1'($urandom_range(0, 1)); rv = 2'($urandom_range(0, 3)); rw = 1'($urandom_range(0, 1));
      d = {$urandom, $urandom};
      if (!w)              tg = "R3 random narrow access";
      else if (v != 2'b00) tg = "R5 random alias access";
      else if (op != 2'b00) tg = "R4 random set/clear";
      else                 tg = "R6 random machine write";
      if (k % 7 == 3) idle("R11 random idle", rv, rw);
      else            access(tg, v, op, w, d, rv, rw);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    run_config(1'b1, 1'b1, 1'b1);
    run_config(1'b0, 1'b1, 1'b1);
    run_config(1'b1, 1'b0, 1'b1);
    run_config(1'b0, 1'b1, 1'b0);
    run_config(1'b1, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule